// File: doc/BRIEF.md
# Flattened double-loop product accumulator

This block forms the sum of every pairwise product between two short signed vectors, one indexed by an outer loop and the other by an inner loop. With both vectors ten elements long, one run adds one hundred terms x[i]*y[j] into a wide signed accumulator. Software or a neighbouring block writes the vector elements one at a time through a shared load port, pulses `start`, and then reads `result` once `done` has pulsed.

The structure is fixed at build time by the `UNROLL_INNER` parameter. With it at 0, a single combined index walks all one hundred (i, j) pairs, the inner index changing fastest, and one multiply-accumulate is issued every cycle. With it at 1, the block first spends one cycle reducing the whole y vector to its sum. It then walks only the outer index, issuing one multiplication x[i]*sum(y) per step. Neither structure spends any cycle entering or leaving an inner loop.

Top module: `dual_loop_mac`

## Requirements
- R1: After reset `busy`, `done` and `result` are 0 and every vector element is 0, so a run started straight after reset yields 0.
- R2: While idle, a cycle with `ld_x_en` (or `ld_y_en`) high writes `ld_data` into x (or y) at element `ld_idx`; an index of LEN_X (LEN_Y) or more writes nothing.
- R3: At `done`, `result` equals the 40-bit signed sum over i in 0..9 and j in 0..9 of x[i]*y[j], elements taken as 16-bit two's complement.
- R4: The accumulator is cleared by an accepted start: `result` reads 0 in the cycle after the start edge.
- R5: With UNROLL_INNER=0, `done` is high in the cycle after the 100th rising edge following the start edge (one term per cycle, no loop entry or exit cycles).
- R6: With UNROLL_INNER=1, `done` is high in the cycle after the 11th rising edge following the start edge (one y-reduction cycle, then ten outer steps).
- R7: `done` is high for exactly one cycle per run, and `busy` is low in that cycle.
- R8: Loads presented while `busy` is high change no vector element.
- R9: A `start` pulse while `busy` is high is ignored; the run in progress keeps its timing and result.
- R10: While idle and without a new start, `result` holds its last value.
- R11: Both structures give the same `result` for the same vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_x_en | input | 1 | Write `ld_data` into the outer-loop vector |
| ld_y_en | input | 1 | Write `ld_data` into the inner-loop vector |
| ld_idx | input | IDX_W (4) | Element index for a load |
| ld_data | input | DATA_W (16) | Signed element value |
| start | input | 1 | One-cycle request to begin a run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the last term is in |
| result | output | ACC_W (40) | Signed accumulator |

## Verification
Both structures are instantiated side by side on the same stimulus. The cleared accumulator is due one edge after the start edge. `done` is due 100 edges after it in the flattened build and 11 edges after it in the unrolled build. The bench counts rising edges from the start edge, samples every output on the falling edge that follows, and records the edge count at which each `done` first appears and how many cycles it stays high. The ignored load and ignored start are injected at edge 5, while both builds are busy. Their absence of effect is read back through `result` and through a second run with no injection.

// File: rtl/dlm_pkg.sv
// Package: shared types for the double-loop product accumulator.
// Assumes: nothing beyond the sequencer states listed here.
package dlm_pkg;

    // Sequencer states; ST_PREP is only reached when the inner loop is unrolled.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_RUN  = 2'd2
    } dlm_state_e;

    // Cycles from an accepted start edge to the edge that adds the last term.
    function automatic int run_cycles(input int len_x, input int len_y, input bit unroll);
        return unroll ? (len_x + 1) : (len_x * len_y);
    endfunction

endpackage

// File: rtl/dlm_vecfile.sv
// Module: dlm_vecfile
// A small register file of signed elements with one write port and every
// element visible at once on a flat read bus (element k at bits k*DATA_W).
// Assumes: the caller gates wr_en with its own busy condition; indices at
// or above DEPTH are dropped here.
module dlm_vecfile #(
    parameter int DEPTH  = 10,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [DEPTH*DATA_W-1:0] rd_flat
);

    genvar k;
    generate
        for (k = 0; k < DEPTH; k++) begin : g_elem
            logic [DATA_W-1:0] elem_q;

            // Hold one element; write it when the index matches.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    elem_q <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(k))) begin
                    elem_q <= wr_data;
                end
            end

            assign rd_flat[k*DATA_W +: DATA_W] = elem_q;
        end
    endgenerate

endmodule

// File: rtl/dlm_sequencer.sv
// Module: dlm_sequencer
// Walks the loop indices for one run. In the flattened variant the inner
// index runs fastest and wraps into the outer one, so all LEN_X*LEN_Y
// pairs come out on consecutive cycles. In the unrolled variant one
// preparation cycle is spent, then only the outer index is walked.
// Assumes: start is ignored unless idle; LEN_X, LEN_Y fit in IDX_W bits.
module dlm_sequencer
    import dlm_pkg::*;
#(
    parameter int LEN_X        = 10,
    parameter int LEN_Y        = 10,
    parameter int IDX_W        = 4,
    parameter bit UNROLL_INNER = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             go,
    output logic             acc_en,
    output logic             sum_en,
    output logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] idx_j,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST_I = IDX_W'(LEN_X - 1);
    localparam logic [IDX_W-1:0] LAST_J = IDX_W'(LEN_Y - 1);

    dlm_state_e       state_q;
    logic [IDX_W-1:0] i_q;
    logic [IDX_W-1:0] j_q;
    logic             last_step;
    logic             done_q;

    assign busy   = (state_q != ST_IDLE);
    assign go     = start && (state_q == ST_IDLE);
    assign acc_en = (state_q == ST_RUN);
    assign sum_en = (state_q == ST_PREP);
    assign idx_i  = i_q;
    assign idx_j  = j_q;
    assign done   = done_q;

    generate
        if (UNROLL_INNER) begin : g_unrolled
            assign last_step = acc_en && (i_q == LAST_I);
            assign j_q       = '0;

            // Advance idle -> reduce y -> outer steps -> idle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    state_q <= ST_IDLE;
                    i_q     <= '0;
                end else begin
                    case (state_q)
                        ST_IDLE: begin
                            if (start) begin
                                state_q <= ST_PREP;
                                i_q     <= '0;
                            end
                        end
                        ST_PREP: state_q <= ST_RUN;
                        ST_RUN: begin
                            if (last_step) begin
                                state_q <= ST_IDLE;
                            end else begin
                                i_q <= i_q + 1'b1;
                            end
                        end
                        default: state_q <= ST_IDLE;
                    endcase
                end
            end
        end else begin : g_flattened
            assign last_step = acc_en && (i_q == LAST_I) && (j_q == LAST_J);

            // Advance one combined (i, j) index per cycle, j fastest.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    state_q <= ST_IDLE;
                    i_q     <= '0;
                    j_q     <= '0;
                end else begin
                    case (state_q)
                        ST_IDLE: begin
                            if (start) begin
                                state_q <= ST_RUN;
                                i_q     <= '0;
                                j_q     <= '0;
                            end
                        end
                        ST_RUN: begin
                            if (j_q == LAST_J) begin
                                j_q <= '0;
                                if (last_step) begin
                                    state_q <= ST_IDLE;
                                end else begin
                                    i_q <= i_q + 1'b1;
                                end
                            end else begin
                                j_q <= j_q + 1'b1;
                            end
                        end
                        default: state_q <= ST_IDLE;
                    endcase
                end
            end
        end
    endgenerate

    // Register the completion pulse on the edge that adds the last term.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= last_step;
        end
    end

endmodule

// File: rtl/dlm_datapath.sv
// Module: dlm_datapath
// Forms one term per enabled cycle and adds it into the accumulator.
// Flattened variant: term = x[i]*y[j] from a single multiplier.
// Unrolled variant: on sum_en all y elements are reduced into a register,
// then term = x[i]*sum(y), still a single multiplier.
// Assumes: idx_i < LEN_X and idx_j < LEN_Y whenever acc_en is high; the
// accumulator is wide enough for LEN_X*LEN_Y worst-case products.
module dlm_datapath #(
    parameter int DATA_W       = 16,
    parameter int ACC_W        = 40,
    parameter int LEN_X        = 10,
    parameter int LEN_Y        = 10,
    parameter int IDX_W        = 4,
    parameter bit UNROLL_INNER = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go,
    input  logic                    acc_en,
    input  logic                    sum_en,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic [IDX_W-1:0]        idx_j,
    input  logic [LEN_X*DATA_W-1:0] x_flat,
    input  logic [LEN_Y*DATA_W-1:0] y_flat,
    output logic [ACC_W-1:0]        acc
);

    localparam int PROD_W = 2 * DATA_W;
    localparam int SUM_W  = DATA_W + $clog2(LEN_Y);
    localparam int WIDE_W = DATA_W + SUM_W;

    logic signed [DATA_W-1:0] xv [LEN_X];
    logic signed [DATA_W-1:0] yv [LEN_Y];
    logic signed [ACC_W-1:0]  term;
    logic signed [ACC_W-1:0]  acc_q;

    genvar k;
    generate
        for (k = 0; k < LEN_X; k++) begin : g_xv
            assign xv[k] = x_flat[k*DATA_W +: DATA_W];
        end
        for (k = 0; k < LEN_Y; k++) begin : g_yv
            assign yv[k] = y_flat[k*DATA_W +: DATA_W];
        end

        if (UNROLL_INNER) begin : g_unrolled
            logic signed [SUM_W-1:0]  ysum_d;
            logic signed [SUM_W-1:0]  ysum_q;
            logic signed [WIDE_W-1:0] prod;
            logic                     unused_idx_j;

            assign unused_idx_j = ^idx_j;

            // Reduce every y element into one signed sum.
            always_comb begin
                ysum_d = '0;
                for (int n = 0; n < LEN_Y; n++) begin
                    ysum_d = ysum_d + SUM_W'(yv[n]);
                end
            end

            // Capture the y sum in the preparation cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ysum_q <= '0;
                end else if (sum_en) begin
                    ysum_q <= ysum_d;
                end
            end

            assign prod = xv[idx_i] * ysum_q;
            assign term = ACC_W'(prod);
        end else begin : g_flattened
            logic signed [PROD_W-1:0] prod;
            logic                     unused_sum_en;

            assign unused_sum_en = sum_en;
            assign prod          = xv[idx_i] * yv[idx_j];
            assign term          = ACC_W'(prod);
        end
    endgenerate

    // Clear on an accepted start, then add one term per run cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (go) begin
            acc_q <= '0;
        end else if (acc_en) begin
            acc_q <= acc_q + term;
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/dual_loop_mac.sv
// Module: dual_loop_mac (top)
// Sum of all pairwise products of two signed vectors, built either as a
// flattened single-index loop or with the inner loop unrolled.
// Assumes: loads and starts arriving while busy are dropped; result is the
// accumulator and holds between runs.
module dual_loop_mac #(
    parameter int DATA_W       = 16,
    parameter int ACC_W        = 40,
    parameter int LEN_X        = 10,
    parameter int LEN_Y        = 10,
    parameter int IDX_W        = $clog2((LEN_X > LEN_Y) ? LEN_X : LEN_Y),
    parameter bit UNROLL_INNER = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_x_en,
    input  logic              ld_y_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [ACC_W-1:0]  result
);

    logic                    go;
    logic                    acc_en;
    logic                    sum_en;
    logic [IDX_W-1:0]        idx_i;
    logic [IDX_W-1:0]        idx_j;
    logic [LEN_X*DATA_W-1:0] x_flat;
    logic [LEN_Y*DATA_W-1:0] y_flat;
    logic                    wr_x;
    logic                    wr_y;

    // Accept loads only while idle and within each vector's length.
    assign wr_x = ld_x_en && !busy && (int'(ld_idx) < LEN_X);
    assign wr_y = ld_y_en && !busy && (int'(ld_idx) < LEN_Y);

    dlm_vecfile #(.DEPTH(LEN_X), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_xfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_x),
        .wr_idx  (ld_idx),
        .wr_data (ld_data),
        .rd_flat (x_flat)
    );

    dlm_vecfile #(.DEPTH(LEN_Y), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_yfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_y),
        .wr_idx  (ld_idx),
        .wr_data (ld_data),
        .rd_flat (y_flat)
    );

    dlm_sequencer #(
        .LEN_X(LEN_X), .LEN_Y(LEN_Y), .IDX_W(IDX_W), .UNROLL_INNER(UNROLL_INNER)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .busy   (busy),
        .go     (go),
        .acc_en (acc_en),
        .sum_en (sum_en),
        .idx_i  (idx_i),
        .idx_j  (idx_j),
        .done   (done)
    );

    dlm_datapath #(
        .DATA_W(DATA_W), .ACC_W(ACC_W), .LEN_X(LEN_X), .LEN_Y(LEN_Y),
        .IDX_W(IDX_W), .UNROLL_INNER(UNROLL_INNER)
    ) u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .acc_en (acc_en),
        .sum_en (sum_en),
        .idx_i  (idx_i),
        .idx_j  (idx_j),
        .x_flat (x_flat),
        .y_flat (y_flat),
        .acc    (result)
    );

endmodule

// File: rtl/dlm_checker.sv
// Module: dlm_checker
// Temporal properties of dual_loop_mac, attached by bind below.
// Assumes: same parameters as the bound instance.
module dlm_checker
    import dlm_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int ACC_W        = 40,
    parameter int LEN_X        = 10,
    parameter int LEN_Y        = 10,
    parameter bit UNROLL_INNER = 1'b0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ld_x_en,
    input logic                    ld_y_en,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic [ACC_W-1:0]        result,
    input logic [LEN_X*DATA_W-1:0] x_flat,
    input logic [LEN_Y*DATA_W-1:0] y_flat
);

    localparam int LAT = run_cycles(LEN_X, LEN_Y, UNROLL_INNER);

    int run_cnt;

    // Count busy cycles of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            run_cnt <= busy ? 1 : 0;
        end else begin
            run_cnt <= run_cnt + 1;
        end
    end

    p_acc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (result == '0));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_busy_ends_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // Covers R5 in the flattened build and R6 in the unrolled build.
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == LAT));

    p_load_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (ld_x_en || ld_y_en)) |=> ($stable(x_flat) && $stable(y_flat)));

    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));

endmodule

bind dual_loop_mac dlm_checker #(
    .DATA_W(DATA_W), .ACC_W(ACC_W), .LEN_X(LEN_X), .LEN_Y(LEN_Y),
    .UNROLL_INNER(UNROLL_INNER)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_x_en (ld_x_en),
    .ld_y_en (ld_y_en),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .result  (result),
    .x_flat  (x_flat),
    .y_flat  (y_flat)
);

// File: tb/dual_loop_mac_test.sv
// Bench: both structures side by side on shared stimulus.
module dual_loop_mac_test;

    localparam int DW = 16;
    localparam int AW = 40;
    localparam int LX = 10;
    localparam int LY = 10;
    localparam int IW = 4;
    localparam int LAT_FLAT = 100;
    localparam int LAT_UNR  = 11;
    localparam int NCASE = 5;
    // Each row {x0, x step, y0, y step}: x[k] = x0 + step*k, likewise y.
    localparam int TBL [NCASE][4] = '{
        '{1, 2, 3, -1},
        '{-7, 300, 1000, -250},
        '{-32768, 0, -32768, 0},
        '{32767, -1, -32768, 0},
        '{0, 0, 5, 5}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_x_en = 1'b0;
    logic          ld_y_en = 1'b0;
    logic [IW-1:0] ld_idx = '0;
    logic [DW-1:0] ld_data = '0;
    logic          start = 1'b0;
    logic          busy_f, done_f, busy_u, done_u;
    logic [AW-1:0] res_f, res_u;

    int checks = 0;
    int errors = 0;
    shortint mx [LX];
    shortint my [LY];

    always #10 clk = ~clk;

    dual_loop_mac #(.UNROLL_INNER(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .ld_x_en(ld_x_en), .ld_y_en(ld_y_en),
        .ld_idx(ld_idx), .ld_data(ld_data), .start(start),
        .busy(busy_f), .done(done_f), .result(res_f)
    );

    dual_loop_mac #(.UNROLL_INNER(1'b1)) uut_unr (
        .clk(clk), .rst_n(rst_n), .ld_x_en(ld_x_en), .ld_y_en(ld_y_en),
        .ld_idx(ld_idx), .ld_data(ld_data), .start(start),
        .busy(busy_u), .done(done_u), .result(res_u)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint expect_sum();
        longint s = 0;
        for (int i = 0; i < LX; i++)
            for (int j = 0; j < LY; j++)
                s += longint'(mx[i]) * longint'(my[j]);
        return s;
    endfunction

    function automatic longint as_signed(input logic [AW-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic load_elem(input bit is_y, input int idx, input int val);
        @(negedge clk);
        ld_x_en = !is_y;
        ld_y_en = is_y;
        ld_idx  = IW'(idx);
        ld_data = DW'(val);
        @(negedge clk);
        ld_x_en = 1'b0;
        ld_y_en = 1'b0;
        if (idx < (is_y ? LY : LX)) begin
            if (is_y) my[idx] = shortint'(val);
            else      mx[idx] = shortint'(val);
        end
    endtask

    // Pulse start and observe both builds; cycle c = edges after the start edge.
    task automatic run_both(input bit inj_ld, input bit inj_start,
                            output int df, output int du, output int nf, output int nu,
                            output longint rf, output longint ru, output bit cleared);
        df = -1; du = -1; nf = 0; nu = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cleared = (res_f == '0) && (res_u == '0);
        for (int c = 1; c <= 110; c++) begin
            if (c == 5 && inj_ld) begin
                ld_x_en = 1'b1;
                ld_y_en = 1'b0;
                ld_idx  = '0;
                ld_data = 16'h1234;
            end
            if (c == 5 && inj_start) start = 1'b1;
            @(negedge clk);
            ld_x_en = 1'b0;
            start   = 1'b0;
            if (done_f) begin nf++; if (df < 0) df = c; end
            if (done_u) begin nu++; if (du < 0) du = c; end
        end
        rf = as_signed(res_f);
        ru = as_signed(res_u);
    endtask

    task automatic check_run(input string tag, input longint exp, input int df, input int du,
                             input int nf, input int nu, input longint rf, input longint ru);
        chk(rf == exp, {"R3 flat ", tag}, rf, exp);
        chk(ru == exp, {"R11 unrolled ", tag}, ru, exp);
        chk(df == LAT_FLAT, {"R5 done cycle ", tag}, df, LAT_FLAT);
        chk(du == LAT_UNR, {"R6 done cycle ", tag}, du, LAT_UNR);
        chk(nf == 1 && nu == 1, {"R7 done pulse count ", tag}, nf * 10 + nu, 11);
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int df, du, nf, nu;
        longint rf, ru, exp, prev_f;
        bit cl;

        for (int k = 0; k < LX; k++) mx[k] = 0;
        for (int k = 0; k < LY; k++) my[k] = 0;

        repeat (3) @(negedge clk);
        // R1: reset state of both builds.
        chk(!busy_f && !done_f && res_f == '0, "R1 flat reset", as_signed(res_f), 0);
        chk(!busy_u && !done_u && res_u == '0, "R1 unrolled reset", as_signed(res_u), 0);
        rst_n = 1'b1;

        // R1: vectors start at zero.
        run_both(1'b0, 1'b0, df, du, nf, nu, rf, ru, cl);
        chk(rf == 0 && ru == 0, "R1 zero vectors", rf + ru, 0);

        // Table walk: R2, R3, R4, R5, R6, R7, R11.
        for (int t = 0; t < NCASE; t++) begin
            for (int k = 0; k < LX; k++) load_elem(1'b0, k, TBL[t][0] + TBL[t][1] * k);
            for (int k = 0; k < LY; k++) load_elem(1'b1, k, TBL[t][2] + TBL[t][3] * k);
            exp = expect_sum();
            run_both(1'b0, 1'b0, df, du, nf, nu, rf, ru, cl);
            chk(cl, "R4 cleared after start", 0, 0);
            check_run($sformatf("case %0d", t), exp, df, du, nf, nu, rf, ru);
        end

        // R10: result holds while idle.
        prev_f = as_signed(res_f);
        repeat (6) @(negedge clk);
        chk(as_signed(res_f) == prev_f, "R10 hold flat", as_signed(res_f), prev_f);
        chk(as_signed(res_u) == prev_f, "R10 hold unrolled", as_signed(res_u), prev_f);

        // R2: out-of-range index writes nothing.
        load_elem(1'b0, 12, 999);
        load_elem(1'b1, 15, -999);
        exp = expect_sum();
        run_both(1'b0, 1'b0, df, du, nf, nu, rf, ru, cl);
        chk(rf == exp && ru == exp, "R2 out-of-range load", rf, exp);

        // R2: a single in-range write lands at its index.
        load_elem(1'b0, 3, -123);
        exp = expect_sum();
        run_both(1'b0, 1'b0, df, du, nf, nu, rf, ru, cl);
        chk(rf == exp && ru == exp, "R2 single element write", ru, exp);

        // R8 and R9: load and start injected mid-run are ignored.
        run_both(1'b1, 1'b1, df, du, nf, nu, rf, ru, cl);
        chk(rf == exp && ru == exp, "R8 load while busy", rf, exp);
        chk(df == LAT_FLAT && du == LAT_UNR, "R9 start while busy", df * 100 + du,
            LAT_FLAT * 100 + LAT_UNR);
        chk(nf == 1 && nu == 1, "R9 no extra run", nf * 10 + nu, 11);
        run_both(1'b0, 1'b0, df, du, nf, nu, rf, ru, cl);
        chk(rf == exp && ru == exp, "R8 element unchanged after busy load", rf, exp);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule